// File: doc/BRIEF.md
# Reservation Station Slot Tracker

This block keeps the occupancy state of a single execution resource's reservation buffer. Dispatch logic sends it four strobes: take a slot, give a slot back, hold the resource, and free the hold. The block answers with a two-bit status that says whether a new instruction may be dispatched to the resource.

A single signed parameter, `BUF_SIZE`, selects the behaviour. At -1 the resource has no buffer limit and always reports available. At 0 the resource is a dispatch hazard: once held, it blocks dispatch until the hold is cleared. At 1 the resource is a one-entry buffer that forces in-order execution. Any larger value gives a buffered resource with that many slots. The free-slot count, the hold flag and a one-cycle overflow pulse are also brought out so that the owner can observe them.

Top module: `slot_tracker`

## Requirements
- R1: While `rstN` is low and after it is released, `freeSlots` equals `BUF_SIZE` when `BUF_SIZE` > 0 and is 0 otherwise. In the same period `held` and `overflowErr` are 0.
- R2: With `BUF_SIZE` = -1, `status` is always 2'b00 (available), whatever strobes arrive.
- R3: With `BUF_SIZE` = 0, `status` is 2'b10 (reserved) while `held` is 1, and 2'b00 (available) otherwise.
- R4: A cycle with `reserveBuf` high and `releaseBuf` low lowers `freeSlots` by one at the next edge if `freeSlots` is nonzero. If `freeSlots` is zero, the cycle leaves it unchanged.
- R5: A cycle with `releaseBuf` high and `reserveBuf` low raises `freeSlots` by one only when `BUF_SIZE` > 0 and `freeSlots` < `BUF_SIZE`. When `BUF_SIZE` > 0 and `freeSlots` = `BUF_SIZE`, the release is dropped and `overflowErr` is high for exactly the following cycle. In every other case `overflowErr` is low.
- R6: A cycle with `reserveBuf` and `releaseBuf` both high leaves `freeSlots` unchanged and raises no error.
- R7: With `BUF_SIZE` > 1, `status` is 2'b00 (available) while `freeSlots` > 0 and 2'b01 (unavailable) while `freeSlots` = 0.
- R8: With `BUF_SIZE` = 1, the resource acts as a single-slot buffer. One reserve makes `status` 2'b01, and a release returns it to 2'b00.
- R9: `setHold` sets `held` at the next edge and `clearHold` clears it. When both are high, `setHold` wins. In any mode other than `BUF_SIZE` = 0, `held` has no effect on `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reserveBuf | input | 1 | Take one buffer slot |
| releaseBuf | input | 1 | Return one buffer slot |
| setHold | input | 1 | Mark the resource held |
| clearHold | input | 1 | Remove the hold |
| status | output | 2 | 00 available, 01 unavailable, 10 reserved |
| freeSlots | output | CNT_W | Current free-slot count |
| held | output | 1 | Hold flag |
| overflowErr | output | 1 | Pulse: a release was dropped at full |

## Verification
Every strobe is registered once. `freeSlots`, `held` and `overflowErr` therefore change at the first clock edge after the cycle in which a strobe is driven. `status` is derived combinationally from that state, so it follows in the same cycle. The bench drives strobes just after a falling edge and advances its reference model at the next rising edge. It compares all four outputs of every instance at the falling edge that follows, so each result is sampled exactly one edge after its cause. Four instances, one per mode, share the stimulus, and each is checked against its own model.

// File: rtl/slot_tracker_pkg.sv
package slot_tracker_pkg;

  typedef enum logic [1:0] {
    ST_AVAIL = 2'b00,
    ST_FULL  = 2'b01,
    ST_HELD  = 2'b10
  } slotStatus_e;

  typedef struct packed {
    logic incSlot;
    logic decSlot;
    logic flagOvf;
    logic holdSet;
    logic holdClr;
  } slotCtl_t;

endpackage

// File: rtl/slot_tracker_ctrl.sv
module slot_tracker_ctrl
  import slot_tracker_pkg::*;
#(
  parameter int BUF_SIZE = 3
) (
  input  logic        reserveBuf,
  input  logic        releaseBuf,
  input  logic        setHold,
  input  logic        clearHold,
  input  logic        cntZero,
  input  logic        cntFull,
  input  logic        holdQ,
  output slotCtl_t    ctl,
  output logic [1:0]  status
);

  localparam bit IS_BUFFERED = (BUF_SIZE > 0);
  localparam bit IS_HAZARD   = (BUF_SIZE == 0);

  logic relOnly;
  logic resOnly;

  assign relOnly = releaseBuf && !reserveBuf;
  assign resOnly = reserveBuf && !releaseBuf;

  always_comb begin
    ctl.incSlot = IS_BUFFERED && relOnly && !cntFull;
    ctl.flagOvf = IS_BUFFERED && relOnly && cntFull;
    ctl.decSlot = resOnly && !cntZero;
    ctl.holdSet = setHold;
    ctl.holdClr = clearHold && !setHold;
  end

  always_comb begin
    if (IS_HAZARD && holdQ)
      status = ST_HELD;
    else if (!IS_BUFFERED || !cntZero)
      status = ST_AVAIL;
    else
      status = ST_FULL;
  end

endmodule

// File: rtl/slot_tracker_dp.sv
module slot_tracker_dp
  import slot_tracker_pkg::*;
#(
  parameter int BUF_SIZE = 3,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotCtl_t         ctl,
  output logic [CNT_W-1:0] freeSlots,
  output logic             cntZero,
  output logic             cntFull,
  output logic             holdQ,
  output logic             ovfQ
);

  localparam int CAP = (BUF_SIZE > 0) ? BUF_SIZE : 0;

  generate
    if (BUF_SIZE > 0) begin : g_counted
      logic [CNT_W-1:0] cntQ;
      always_ff @(posedge clk) begin
        if (!rstN)
          cntQ <= CNT_W'(CAP);
        else if (ctl.incSlot)
          cntQ <= cntQ + 1'b1;
        else if (ctl.decSlot)
          cntQ <= cntQ - 1'b1;
      end
      assign freeSlots = cntQ;
    end else begin : g_uncounted
      assign freeSlots = '0;
    end
  endgenerate

  assign cntZero = (freeSlots == '0);
  assign cntFull = (freeSlots == CNT_W'(CAP));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= 1'b0;
      ovfQ  <= 1'b0;
    end else begin
      ovfQ <= ctl.flagOvf;
      if (ctl.holdSet)
        holdQ <= 1'b1;
      else if (ctl.holdClr)
        holdQ <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
  import slot_tracker_pkg::*;
#(
  parameter int BUF_SIZE = 3,
  localparam int CAP_L   = (BUF_SIZE > 0) ? BUF_SIZE : 1,
  localparam int CNT_W   = $clog2(CAP_L + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reserveBuf,
  input  logic             releaseBuf,
  input  logic             setHold,
  input  logic             clearHold,
  output logic [1:0]       status,
  output logic [CNT_W-1:0] freeSlots,
  output logic             held,
  output logic             overflowErr
);

  slotCtl_t ctl;
  logic     cntZero;
  logic     cntFull;

  slot_tracker_ctrl #(.BUF_SIZE(BUF_SIZE)) u_ctrl (
    .reserveBuf (reserveBuf),
    .releaseBuf (releaseBuf),
    .setHold    (setHold),
    .clearHold  (clearHold),
    .cntZero    (cntZero),
    .cntFull    (cntFull),
    .holdQ      (held),
    .ctl        (ctl),
    .status     (status)
  );

  slot_tracker_dp #(.BUF_SIZE(BUF_SIZE), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .freeSlots (freeSlots),
    .cntZero   (cntZero),
    .cntFull   (cntFull),
    .holdQ     (held),
    .ovfQ      (overflowErr)
  );

endmodule

// File: rtl/slot_tracker_chk.sv
module slot_tracker_chk #(
  parameter int BUF_SIZE = 3,
  parameter int CNT_W    = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             reserveBuf,
  input logic             releaseBuf,
  input logic             setHold,
  input logic             clearHold,
  input logic [1:0]       status,
  input logic [CNT_W-1:0] freeSlots,
  input logic             held,
  input logic             overflowErr
);

  localparam int CAP = (BUF_SIZE > 0) ? BUF_SIZE : 0;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(freeSlots) <= CAP); // R5

  AST_DEC_ON_RESERVE: assert property (@(posedge clk) disable iff (!rstN)
    reserveBuf && !releaseBuf && freeSlots != '0 |=> int'(freeSlots) == int'($past(freeSlots)) - 1); // R4

  AST_BOTH_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    reserveBuf && releaseBuf |=> $stable(freeSlots) && !overflowErr); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    setHold |=> held); // R9

  AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    clearHold && !setHold |=> !held); // R9

  generate
    if (BUF_SIZE < 0) begin : g_unb
      AST_UNBOUNDED_AVAIL: assert property (@(posedge clk) disable iff (!rstN)
        status == 2'b00); // R2
    end else if (BUF_SIZE == 0) begin : g_haz
      AST_HAZARD_HELD: assert property (@(posedge clk) disable iff (!rstN)
        held |-> status == 2'b10); // R3
    end else begin : g_buf
      AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
        releaseBuf && !reserveBuf && int'(freeSlots) == CAP |=> overflowErr && $stable(freeSlots)); // R5
      AST_EMPTY_UNAVAIL: assert property (@(posedge clk) disable iff (!rstN)
        freeSlots == '0 |-> status == 2'b01); // R7
    end
  endgenerate

endmodule

bind slot_tracker slot_tracker_chk #(.BUF_SIZE(BUF_SIZE), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reserveBuf  (reserveBuf),
  .releaseBuf  (releaseBuf),
  .setHold     (setHold),
  .clearHold   (clearHold),
  .status      (status),
  .freeSlots   (freeSlots),
  .held        (held),
  .overflowErr (overflowErr)
);

// File: tb/slot_tracker_tb.sv
module slot_tracker_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reserveBuf = 1'b0, releaseBuf = 1'b0, setHold = 1'b0, clearHold = 1'b0;

  always #10 clk = ~clk;

  logic [1:0] st0, st1, st2, st3;
  logic [1:0] fs0;
  logic [0:0] fs1, fs2, fs3;
  logic       hd0, hd1, hd2, hd3, ov0, ov1, ov2, ov3;

  slot_tracker #(.BUF_SIZE(3)) u_dut (.clk(clk), .rstN(rstN), .reserveBuf(reserveBuf),
    .releaseBuf(releaseBuf), .setHold(setHold), .clearHold(clearHold),
    .status(st0), .freeSlots(fs0), .held(hd0), .overflowErr(ov0));
  slot_tracker #(.BUF_SIZE(-1)) u_dutUnb (.clk(clk), .rstN(rstN), .reserveBuf(reserveBuf),
    .releaseBuf(releaseBuf), .setHold(setHold), .clearHold(clearHold),
    .status(st1), .freeSlots(fs1), .held(hd1), .overflowErr(ov1));
  slot_tracker #(.BUF_SIZE(0)) u_dutHaz (.clk(clk), .rstN(rstN), .reserveBuf(reserveBuf),
    .releaseBuf(releaseBuf), .setHold(setHold), .clearHold(clearHold),
    .status(st2), .freeSlots(fs2), .held(hd2), .overflowErr(ov2));
  slot_tracker #(.BUF_SIZE(1)) u_dutOne (.clk(clk), .rstN(rstN), .reserveBuf(reserveBuf),
    .releaseBuf(releaseBuf), .setHold(setHold), .clearHold(clearHold),
    .status(st3), .freeSlots(fs3), .held(hd3), .overflowErr(ov3));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int sizeM [4] = '{3, -1, 0, 1};
  int cntM  [4];
  int holdM [4];
  int errM  [4];

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int expStatus(input int i);
    if (sizeM[i] == 0 && holdM[i] != 0) return 2;
    if (sizeM[i] <= 0 || cntM[i] > 0) return 0;
    return 1;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      cntM[i]  = (sizeM[i] > 0) ? sizeM[i] : 0;
      holdM[i] = 0;
      errM[i]  = 0;
    end
  endtask

  task automatic modelStep();
    for (int i = 0; i < 4; i++) begin
      errM[i] = 0;
      if (reserveBuf && !releaseBuf) begin
        if (cntM[i] > 0) cntM[i]--;
      end else if (releaseBuf && !reserveBuf && sizeM[i] > 0) begin
        if (cntM[i] < sizeM[i]) cntM[i]++;
        else errM[i] = 1;
      end
      if (setHold) holdM[i] = 1;
      else if (clearHold) holdM[i] = 0;
    end
  endtask

  task automatic compareAll();
    int st[4], fs[4], hd[4], ov[4];
    string stTag[4] = '{"R7", "R2", "R3", "R8"};
    st = '{int'(st0), int'(st1), int'(st2), int'(st3)};
    fs = '{int'(fs0), int'(fs1), int'(fs2), int'(fs3)};
    hd = '{int'(hd0), int'(hd1), int'(hd2), int'(hd3)};
    ov = '{int'(ov0), int'(ov1), int'(ov2), int'(ov3)};
    for (int i = 0; i < 4; i++) begin
      check(stTag[i], st[i], expStatus(i), $sformatf("status size=%0d", sizeM[i]));
      check("R4", fs[i], cntM[i], $sformatf("freeSlots size=%0d", sizeM[i]));
      check("R9", hd[i], holdM[i], $sformatf("held size=%0d", sizeM[i]));
      check("R5", ov[i], errM[i], $sformatf("overflowErr size=%0d", sizeM[i]));
    end
  endtask

  task automatic step(input bit rv, input bit rl, input bit sh, input bit ch);
    reserveBuf = rv; releaseBuf = rl; setHold = sh; clearHold = ch;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    reserveBuf = 0; releaseBuf = 0; setHold = 0; clearHold = 0;
    compareAll();
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state of every mode
    check("R1", int'(fs0), 3, "freeSlots after reset size=3");
    check("R1", int'(fs1) + int'(fs2), 0, "freeSlots after reset size<=0");
    check("R1", int'(fs3), 1, "freeSlots after reset size=1");
    check("R1", int'(hd0) + int'(hd2) + int'(ov0) + int'(ov3), 0, "held/overflow after reset");
    compareAll();

    // drain past empty (R4, R7, R8)
    repeat (4) step(1, 0, 0, 0);
    check("R7", int'(st0), 1, "size=3 empty reports unavailable");
    check("R8", int'(st3), 1, "size=1 after reserve reports unavailable");
    // R6 at zero: both strobes change nothing
    step(1, 1, 0, 0);
    check("R6", int'(fs0), 0, "both at empty");
    // refill and overflow (R5)
    repeat (4) step(0, 1, 0, 0);
    check("R5", int'(fs0), 3, "refilled to cap");
    step(0, 1, 0, 0);
    check("R5", int'(ov0), 1, "dropped release raises error");
    // R6 at full: no error
    step(1, 1, 0, 0);
    check("R6", int'(fs0) + int'(ov0), 3, "both at full");
    // hold handling (R3, R9)
    step(0, 0, 1, 0);
    check("R3", int'(st2), 2, "hazard held reports reserved");
    check("R9", int'(st0), 0, "hold ignored in buffered mode");
    step(0, 0, 1, 1);
    check("R9", int'(hd2), 1, "set wins over clear");
    step(0, 0, 0, 1);
    check("R3", int'(st2), 0, "hazard released reports available");
    step(1, 0, 1, 0);
    check("R2", int'(st1), 0, "unbounded stays available");

    // mixed pattern
    for (int k = 0; k < 400; k++) begin
      int r = $urandom;
      step(r[0], r[1] & r[2], r[3] & r[4], r[5] & r[6]);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule